// File: doc/BRIEF.md
# Vector Prefix Step Sequencer

This block sits in the instruction fetch path of a 64-bit core. It looks at each 32-bit word fetched at the current program counter and decides whether that word is a vector prefix. A prefix word carries a 24-bit remap field. The block captures that field and then asks for the suffix word at PC+4. A plain word is handed on to execution at once.

The block also owns a 32-bit vector-state register. This register holds the vector length and the source element step. For a prefixed instruction whose destination is a vector, the block runs a sub-program-counter loop. On each retire the step index goes up by one and the same PC is fetched again. When the last element retires, the step clears and the PC moves on by 8. Plain instructions move the PC by 4. A prefixed instruction met with a vector length of zero is skipped.

A four-state machine controls the block:
- HEAD waits for the word at the PC. On a prefix it moves to TAIL. On a plain word it moves to RUN.
- TAIL waits for the suffix word. It moves to SKIP when the vector length is zero and to RUN otherwise.
- RUN waits for retire and then returns to HEAD. It either holds the PC (loop) or advances it.
- SKIP lasts one cycle. It advances the PC by 8 and returns to HEAD.

Top module: `vstep_seq`

## Requirements
- R1: After reset `cur_pc` and `fetch_addr` equal `RESET_PC`. The vector-state register is zero, so `step`=0. `skip`=0, and `remap`=0.
- R2: In HEAD, `fetch_addr` is `cur_pc`. A word is a prefix when bits 31:26 equal 6'b000001 and bits 24 and 22 are both 1 (bit 0 is the least significant bit). After a prefix word is accepted, `fetch_addr` becomes `cur_pc`+4 for the suffix fetch. A plain word goes straight to RUN without a suffix fetch.
- R3: For a prefixed instruction, `remap` in TAIL, RUN and SKIP is {word[25], word[23], word[21:0]}. `remap` is zero in HEAD and for any plain instruction.
- R4: `next_pc` is `cur_pc`+8 for a prefixed instruction and `cur_pc`+4 for a plain one. In HEAD the value follows the word being presented.
- R5: A prefixed instruction seen with VL=0 produces exactly one SKIP cycle with `skip`=1. In that cycle the step is unchanged. Afterwards `cur_pc` has advanced by 8, and no retire is awaited.
- R6: A retire in RUN with a prefixed instruction, `dest_vec`=1 and step+1 < VL raises the step by one and leaves `cur_pc` (and `next_pc`) equal to the current PC. The same PC is then fetched again.
- R7: A retire of a prefixed instruction that is on its last element (step+1 >= VL) or has a scalar destination clears the step to 0 and advances the PC by 8.
- R8: A retire of a plain instruction advances the PC by 4 and never changes the step, whatever `dest_vec` says.
- R9: `vs_wr_en` loads `vs_wr_data` into the vector-state register. In that register, bits 31:25 hold maxvl, 24:18 VL, 17:11 step, 10:4 dststep, 3:2 subvl and 1:0 svstep. If a write and a retire fall in the same cycle, the write wins the register. The PC and the state machine still follow the decision taken from the pre-write values.
- R10: While `fetch_vld` is low in HEAD or TAIL, the state, `cur_pc` and `fetch_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_word | input | 32 | Word returned for `fetch_addr` |
| fetch_vld | input | 1 | `fetch_word` is valid this cycle |
| dest_vec | input | 1 | Decoder reports a vector destination |
| retire | input | 1 | Current instruction (element) retires |
| vs_wr_en | input | 1 | Load the vector-state register |
| vs_wr_data | input | 32 | Data for the vector-state load |
| fetch_addr | output | PC_W | Address to fetch next |
| cur_pc | output | PC_W | Current program counter |
| next_pc | output | PC_W | Program counter after this step |
| remap | output | 24 | Remap field of the current prefix |
| step | output | 7 | Current source element step |
| skip | output | 1 | Instruction skipped (VL=0) |
| vstate | output | 32 | Vector-state register contents |

## Verification
The two functions that can fall in the same cycle are a retire in RUN, which updates the step, and a load through the vector-state write port. The bench provokes this collision in a directed case and in a share of random instructions by raising `vs_wr_en` together with `retire`. It judges the outcome on two counts. First, the PC must follow the loop decision made from the old step and VL. Second, the register must afterwards show exactly the written word, and the next loop pass must run from that new step.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    localparam int WORD_W  = 32;
    localparam int REMAP_W = 24;
    localparam int FLD_W   = 7;

    // vector-state register field positions (bit 0 = LSB)
    localparam int MAXVL_LSB  = 25;
    localparam int VL_LSB     = 18;
    localparam int SRC_LSB    = 11;
    localparam int DST_LSB    = 4;
    localparam int SUBVL_LSB  = 2;
    localparam int SVSTEP_LSB = 0;

    localparam logic [5:0] PFX_MAJOR = 6'b000001;

    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,
        ST_TAIL = 2'd1,
        ST_RUN  = 2'd2,
        ST_SKIP = 2'd3
    } seq_state_e;

endpackage

// File: rtl/vstep_prefix_dec.sv
module vstep_prefix_dec
    import vstep_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    output logic               is_pfx,
    output logic [REMAP_W-1:0] remap
);
    // positions are counted from the MSB in the word format
    localparam int TAIL_N  = REMAP_W - 2;
    localparam int TAIL_M0 = 10;

    function automatic int msb0(input int i);
        return WORD_W - 1 - i;
    endfunction

    assign is_pfx = (word[msb0(0):msb0(5)] == PFX_MAJOR)
                  && word[msb0(7)] && word[msb0(9)];

    assign remap[REMAP_W-1] = word[msb0(6)];
    assign remap[REMAP_W-2] = word[msb0(8)];

    for (genvar k = 0; k < TAIL_N; k++) begin : g_tail
        assign remap[TAIL_N-1-k] = word[msb0(TAIL_M0 + k)];
    end

endmodule

// File: rtl/vstep_vstate.sv
module vstep_vstate
    import vstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              step_inc,
    input  logic              step_clr,
    output logic [WORD_W-1:0] vs_q,
    output logic [FLD_W-1:0]  vl,
    output logic [FLD_W-1:0]  srcstep
);
    assign vl      = vs_q[VL_LSB  +: FLD_W];
    assign srcstep = vs_q[SRC_LSB +: FLD_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= '0;
        end else if (wr_en) begin
            vs_q <= wr_data;
        end else if (step_inc) begin
            vs_q[SRC_LSB +: FLD_W] <= srcstep + FLD_W'(1);
        end else if (step_clr) begin
            vs_q[SRC_LSB +: FLD_W] <= '0;
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_inc) |=> (srcstep == $past(srcstep) + FLD_W'(1))); // R6
    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && step_clr) |=> (srcstep == '0)); // R7
    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_inc && step_clr)); // R7
    AST_VS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step_inc && !step_clr) |=> $stable(vs_q)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vs_q == $past(wr_data))); // R9

endmodule

// File: rtl/vstep_pc.sv
module vstep_pc #(
    parameter int              PC_W     = 64,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_en,
    input  logic            adv_wide,
    output logic [PC_W-1:0] cur_pc,
    output logic [PC_W-1:0] pc_p4,
    output logic [PC_W-1:0] pc_p8
);
    localparam logic [PC_W-1:0] NARROW = PC_W'(4);
    localparam logic [PC_W-1:0] WIDE   = PC_W'(8);

    assign pc_p4 = cur_pc + NARROW;
    assign pc_p8 = cur_pc + WIDE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pc <= RESET_PC;
        end else if (adv_en) begin
            cur_pc <= adv_wide ? pc_p8 : pc_p4;
        end
    end

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> (cur_pc == $past(cur_pc) + ($past(adv_wide) ? WIDE : NARROW))); // R4
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(cur_pc)); // R6

endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
    import vstep_pkg::*;
#(
    parameter int              PC_W     = 64,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  fetch_word,
    input  logic               fetch_vld,
    input  logic               dest_vec,
    input  logic               retire,
    input  logic               vs_wr_en,
    input  logic [WORD_W-1:0]  vs_wr_data,
    output logic [PC_W-1:0]    fetch_addr,
    output logic [PC_W-1:0]    cur_pc,
    output logic [PC_W-1:0]    next_pc,
    output logic [REMAP_W-1:0] remap,
    output logic [FLD_W-1:0]   step,
    output logic               skip,
    output logic [WORD_W-1:0]  vstate
);
    seq_state_e state_q, state_d;

    logic               pfx_hit;
    logic [REMAP_W-1:0] remap_w;
    logic               pfx_q;
    logic [REMAP_W-1:0] remap_q;
    logic [FLD_W-1:0]   vl;
    logic [FLD_W-1:0]   srcstep;
    logic [PC_W-1:0]    pc_p4, pc_p8;
    logic               loop_more;
    logic               adv_en, step_inc, step_clr, capture;

    vstep_prefix_dec u_dec (
        .word   (fetch_word),
        .is_pfx (pfx_hit),
        .remap  (remap_w)
    );

    vstep_vstate u_vs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (vs_wr_en),
        .wr_data  (vs_wr_data),
        .step_inc (step_inc),
        .step_clr (step_clr),
        .vs_q     (vstate),
        .vl       (vl),
        .srcstep  (srcstep)
    );

    vstep_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_en   (adv_en),
        .adv_wide (pfx_q),
        .cur_pc   (cur_pc),
        .pc_p4    (pc_p4),
        .pc_p8    (pc_p8)
    );

    // another element remains after this one
    assign loop_more = pfx_q && dest_vec
                     && ((FLD_W+1)'(srcstep) + (FLD_W+1)'(1) < (FLD_W+1)'(vl));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HEAD;
        else        state_q <= state_d;
    end

    // captured instruction info
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfx_q   <= 1'b0;
            remap_q <= '0;
        end else if (capture) begin
            pfx_q   <= pfx_hit;
            remap_q <= pfx_hit ? remap_w : '0;
        end
    end

    // next state and control strobes
    always_comb begin
        state_d  = state_q;
        capture  = 1'b0;
        adv_en   = 1'b0;
        step_inc = 1'b0;
        step_clr = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                if (fetch_vld) begin
                    capture = 1'b1;
                    state_d = pfx_hit ? ST_TAIL : ST_RUN;
                end
            end
            ST_TAIL: begin
                if (fetch_vld) state_d = (vl == '0) ? ST_SKIP : ST_RUN;
            end
            ST_RUN: begin
                if (retire) begin
                    state_d = ST_HEAD;
                    if (loop_more) begin
                        step_inc = 1'b1;
                    end else begin
                        adv_en   = 1'b1;
                        step_clr = pfx_q;
                    end
                end
            end
            ST_SKIP: begin
                adv_en  = 1'b1;
                state_d = ST_HEAD;
            end
            default: state_d = ST_HEAD;
        endcase
    end

    // outputs
    always_comb begin
        fetch_addr = cur_pc;
        next_pc    = pfx_q ? pc_p8 : pc_p4;
        unique case (state_q)
            ST_HEAD: next_pc = pfx_hit ? pc_p8 : pc_p4;
            ST_TAIL: begin
                fetch_addr = pc_p4;
                next_pc    = pc_p8;
            end
            ST_RUN:  next_pc = loop_more ? cur_pc : (pfx_q ? pc_p8 : pc_p4);
            ST_SKIP: next_pc = pc_p8;
            default: next_pc = pc_p4;
        endcase
        remap = (state_q != ST_HEAD && pfx_q) ? remap_q : '0;
        skip  = (state_q == ST_SKIP);
        step  = srcstep;
    end

    AST_REMAP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !pfx_q |-> (remap == '0)); // R3
    AST_SKIP_PREFIXED: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> pfx_q); // R5
    AST_SKIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> !skip); // R5
    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && retire && loop_more) |=> (cur_pc == $past(cur_pc))); // R6
    AST_STALL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEAD && !fetch_vld) |=> (state_q == ST_HEAD && $stable(fetch_addr))); // R10
    AST_STALL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && !fetch_vld) |=> (state_q == ST_TAIL && $stable(cur_pc))); // R10

endmodule

// File: tb/vstep_seq_test.sv
`timescale 1ns/1ps
module vstep_seq_test;
    localparam int PC_W = 64;
    localparam logic [PC_W-1:0] RST_PC = 64'h0000_0000_0000_1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     fetch_word = '0;
    logic            fetch_vld = 1'b0;
    logic            dest_vec = 1'b0;
    logic            retire = 1'b0;
    logic            vs_wr_en = 1'b0;
    logic [31:0]     vs_wr_data = '0;
    logic [PC_W-1:0] fetch_addr, cur_pc, next_pc;
    logic [23:0]     remap;
    logic [6:0]      step;
    logic            skip;
    logic [31:0]     vstate;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [PC_W-1:0] exp_pc;
    logic [31:0]     exp_vs;

    always #2 clk = ~clk;

    vstep_seq #(.PC_W(PC_W), .RESET_PC(RST_PC)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .fetch_vld(fetch_vld),
        .dest_vec(dest_vec), .retire(retire), .vs_wr_en(vs_wr_en),
        .vs_wr_data(vs_wr_data), .fetch_addr(fetch_addr), .cur_pc(cur_pc),
        .next_pc(next_pc), .remap(remap), .step(step), .skip(skip), .vstate(vstate)
    );

    function automatic bit f_pfx(input logic [31:0] w);
        return (w[31:26] == 6'b000001) && w[24] && w[22];
    endfunction
    function automatic logic [23:0] f_remap(input logic [31:0] w);
        return {w[25], w[23], w[21:0]};
    endfunction
    function automatic logic [6:0] f_vl(input logic [31:0] v);
        return v[24:18];
    endfunction
    function automatic logic [6:0] f_src(input logic [31:0] v);
        return v[17:11];
    endfunction
    function automatic logic [31:0] mk_vs(input logic [6:0] vl, input logic [6:0] src,
                                          input logic [31:0] junk);
        return {junk[31:25], vl, src, junk[10:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_vs(input logic [31:0] v);
        vs_wr_en = 1'b1; vs_wr_data = v;
        @(negedge clk);
        vs_wr_en = 1'b0;
        exp_vs = v;
        chk(vstate == v, "R9 load", vstate, v);
        chk(step == f_src(v), "R9 step field", step, f_src(v));
    endtask

    task automatic run_pass(input logic [31:0] w, input bit dv, input bit coll,
                            input logic [31:0] wd, output bit more);
        bit p;
        bit cont;
        logic [6:0] vl, src;
        logic [PC_W-1:0] inc;
        p = f_pfx(w);
        vl = f_vl(exp_vs);
        src = f_src(exp_vs);
        inc = p ? 64'd8 : 64'd4;
        more = 1'b0;
        chk(fetch_addr == exp_pc, "R2 head addr", fetch_addr, exp_pc);
        chk(remap == '0, "R3 head remap", remap, 0);
        fetch_word = w; fetch_vld = 1'b1;
        #1;
        chk(next_pc == exp_pc + inc, "R4 head next", next_pc, exp_pc + inc);
        @(negedge clk);
        fetch_vld = 1'b0;
        if (p) begin
            chk(fetch_addr == exp_pc + 64'd4, "R2 suffix addr", fetch_addr, exp_pc + 64'd4);
            chk(remap == f_remap(w), "R3 remap", remap, f_remap(w));
            fetch_word = $urandom; fetch_vld = 1'b1;
            @(negedge clk);
            fetch_vld = 1'b0;
            if (vl == 7'd0) begin
                chk(skip == 1'b1, "R5 skip", skip, 1);
                chk(step == src, "R5 step kept", step, src);
                chk(next_pc == exp_pc + 64'd8, "R5 next", next_pc, exp_pc + 64'd8);
                @(negedge clk);
                exp_pc = exp_pc + 64'd8;
                chk(cur_pc == exp_pc, "R5 pc", cur_pc, exp_pc);
                chk(skip == 1'b0, "R5 skip drop", skip, 0);
                return;
            end
        end else begin
            chk(remap == '0, "R3 plain remap", remap, 0);
        end
        chk(skip == 1'b0, "R5 no skip", skip, 0);
        chk(step == src, "R6 step", step, src);
        chk(cur_pc == exp_pc, "R6 pc run", cur_pc, exp_pc);
        cont = p && dv && ({1'b0, src} + 8'd1 < {1'b0, vl});
        retire = 1'b1; dest_vec = dv;
        if (coll) begin vs_wr_en = 1'b1; vs_wr_data = wd; end
        #1;
        chk(next_pc == (cont ? exp_pc : exp_pc + inc), cont ? "R6 next" : "R7 next",
            next_pc, cont ? exp_pc : exp_pc + inc);
        @(negedge clk);
        retire = 1'b0; vs_wr_en = 1'b0;
        if (coll)      exp_vs = wd;
        else if (cont) exp_vs[17:11] = src + 7'd1;
        else if (p)    exp_vs[17:11] = 7'd0;
        if (!cont) exp_pc = exp_pc + inc;
        chk(cur_pc == exp_pc, cont ? "R6 pc held" : (p ? "R7 pc" : "R8 pc"), cur_pc, exp_pc);
        chk(step == f_src(exp_vs),
            coll ? "R9 collide" : (p ? (cont ? "R6 inc" : "R7 clear") : "R8 step kept"),
            step, f_src(exp_vs));
        if (coll) chk(vstate == exp_vs, "R9 collide word", vstate, exp_vs);
        more = cont;
    endtask

    task automatic run_insn(input logic [31:0] w, input bit dv, input bit coll,
                            input logic [31:0] wd);
        bit more;
        run_pass(w, dv, coll, wd, more);
        while (more) run_pass(w, dv, 1'b0, '0, more);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd9137));
        exp_pc = RST_PC;
        exp_vs = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cur_pc == RST_PC, "R1 pc", cur_pc, RST_PC);
        chk(fetch_addr == RST_PC, "R1 fetch", fetch_addr, RST_PC);
        chk(step == 0 && vstate == 0, "R1 state", vstate, 0);
        chk(skip == 0 && remap == 0, "R1 outs", {skip, remap}, 0);

        // R10 stall in HEAD
        repeat (2) @(negedge clk);
        chk(fetch_addr == exp_pc && cur_pc == exp_pc, "R10 stall", fetch_addr, exp_pc);

        // R6/R7 vector loop of three elements
        load_vs(mk_vs(7'd3, 7'd0, 32'hA5A5_A5A5));
        run_insn(32'h07FF_FFFF, 1'b1, 1'b0, '0);
        // R7 scalar destination
        run_insn(32'h0540_1234, 1'b0, 1'b0, '0);
        // R8 plain words near a prefix, vector destination
        load_vs(mk_vs(7'd4, 7'd2, 32'h0));
        run_insn(32'h0500_0000, 1'b1, 1'b0, '0);
        run_insn(32'h0440_0000, 1'b1, 1'b0, '0);
        run_insn(32'h4540_0000, 1'b1, 1'b0, '0);
        // R5 VL zero
        load_vs(mk_vs(7'd0, 7'd0, 32'hFFFF_FFFF));
        run_insn(32'h05C0_00FF, 1'b1, 1'b0, '0);
        // R9 collision of write and retire
        load_vs(mk_vs(7'd4, 7'd0, 32'h0));
        run_insn(32'h0540_0001, 1'b1, 1'b1, mk_vs(7'd4, 7'd3, 32'h1234_5678));

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r, w, wd;
            logic [6:0] vl, src;
            bit dv, coll;
            r = $urandom;
            if ($urandom % 2) w = {6'b000001, r[25], 1'b1, r[23], 1'b1, r[21:0]};
            else              w = $urandom;
            dv = $urandom % 2;
            if ($urandom % 3 == 0) begin
                vl = 7'($urandom % 6);
                src = (vl == 0) ? 7'd0 : 7'($urandom % vl);
                load_vs(mk_vs(vl, src, $urandom));
            end
            coll = ($urandom % 10 == 0);
            vl = 7'($urandom % 6);
            src = (vl == 0) ? 7'd0 : 7'($urandom % vl);
            wd = mk_vs(vl, src, $urandom);
            run_insn(w, dv, coll, wd);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule